// File: doc/BRIEF.md
# Programmable Nested-Majority Gate with Defect Injection and Short-Set Tester

This block models a five-input universal logic cell. The cell works as two majority voters in series. The inner voter takes the inverted first input, the plain second input and the inverted third input. The outer voter combines that inner result with the fourth and fifth inputs. Tying some inputs to constants turns the cell into NAND, NOR and several two-level gates. A two-bit defect selector can replace the correct function with one of three faulty functions. Each faulty function is the one a displaced cell produces. This lets a surrounding test flow be exercised against known bad behaviour.

A small sequential tester wraps one copy of the cell. After a start pulse it applies one of two short test sets, one vector per clock. It compares the response of the cell under test with a fault-free reference copy. It raises a sticky detect flag at the first disagreement and records the vector that caused it.

A ripple-free one-bit full adder built from three fault-free cells is exposed as a usage example of the cell.

Top module: `nmaj_aoi_top`

## Requirements
- R1: With defect select 0, gateOut = MAJ(gateD, gateE, MAJ(!gateA, gateB, !gateC)) for every input pattern. MAJ is the two-of-three majority.
- R2: Tied inputs program the fault-free cell. With gateD=0, gateE=1 and gateB=1 the output is NAND(gateA, gateC). With gateD=0, gateE=1 and gateB=0 the output is NOR(gateA, gateC). With gateA=0 and gateD=0 the output is gateE AND (gateB OR !gateC).
- R3: With defect select 1, gateOut = MAJ(gateB, gateD, gateE), so gateA and gateC have no effect.
- R4: With defect select 2, gateOut equals gateB alone.
- R5: With defect select 3, gateOut = (!D AND !E) OR ((!D OR !E) AND (!A AND B OR B AND !C OR !A AND !B AND !C)).
- R6: In fault-free mode the cell is self-dual. Complementing all five inputs complements the output, for all 32 patterns.
- R7: A tstStart pulse while idle begins a run. tstBusy is high for exactly one cycle per vector. tstDone rises in the cycle that follows the last vector and stays high until the next accepted start. Busy and done are never high together.
- R8: tstDetect goes high on the first vector whose cell-under-test response differs from the fault-free response. tstFailVec holds that vector, coded as {A,B,C,D,E} with A in bit 4. Both hold until the next accepted start, which clears them, and they are 0 when nothing mismatches.
- R9: tstSet=0 selects the two-vector displacement set: 00000, then 00001. This set detects every nonzero defect select. With defect select 0 no run ever detects.
- R10: tstSet=1 selects the four-vector pin-fault set, applied in this order: 01110, 00101, 00000, 00001.
- R11: tstStart while busy is ignored. The run in progress keeps its length, its test set and its results.
- R12: addCarry = MAJ(addA, addB, addCin) and addSum = addA XOR addB XOR addCin, each built from fault-free cells.
- R13: After reset tstBusy, tstDone, tstDetect and tstFailVec are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tester clock |
| rstN | input | 1 | Active-low asynchronous reset |
| gateA | input | 1 | Cell input A (inverted into inner voter) |
| gateB | input | 1 | Cell input B |
| gateC | input | 1 | Cell input C (inverted into inner voter) |
| gateD | input | 1 | Cell input D (outer voter) |
| gateE | input | 1 | Cell input E (outer voter) |
| gateMode | input | 2 | Defect select for the direct cell, 0 = fault-free |
| gateOut | output | 1 | Direct cell output |
| addA | input | 1 | Adder operand a |
| addB | input | 1 | Adder operand b |
| addCin | input | 1 | Adder carry in |
| addSum | output | 1 | Adder sum |
| addCarry | output | 1 | Adder carry out |
| tstStart | input | 1 | Start a tester run when idle |
| tstSet | input | 1 | Test set select, 0 = displacement, 1 = pin-fault |
| tstMode | input | 2 | Defect select injected into the cell under test |
| tstBusy | output | 1 | Tester applying vectors |
| tstDone | output | 1 | Last run finished |
| tstDetect | output | 1 | Mismatch seen in the last run |
| tstFailVec | output | 5 | First mismatching vector {A,B,C,D,E} |

## Verification
The tester checks assume that tstMode stays constant for the whole of a run. The fault-free check in particular relates a rising detect flag to the defect select of the previous cycle. The adder checks assume the adder inputs are driven to known values from reset onward. The stimulus keeps to both assumptions: the bench sets the defect select before each start pulse and holds it until done, and it drives every input to 0 before reset is released. The only start pulse that lands during a run is the deliberate one that probes the ignore rule. Its test-set value differs from the running one, so a wrongly accepted start would show up at the ports.

// File: rtl/nmaj_aoi_pkg.sv
package nmaj_aoi_pkg;

  // defect selector encoding (2 bits)
  typedef enum logic [1:0] {
    DM_NONE = 2'd0,  // fault-free nested majority
    DM_BMOD = 2'd1,  // B cell moved a little: plain majority of B, D, E
    DM_BSEV = 2'd2,  // B cell moved far: output follows B
    DM_OUTC = 2'd3   // output cell moved
  } defectMode_t;

  localparam int VEC_W    = 5;
  localparam int DISP_LEN = 2;
  localparam int PIN_LEN  = 4;
  localparam int MAX_LEN  = (PIN_LEN > DISP_LEN) ? PIN_LEN : DISP_LEN;
  localparam int IDX_W    = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;
  localparam int LEN_W    = IDX_W + 1;

  // control -> datapath strobes
  typedef struct packed {
    logic             clearRes;  // accepted start: wipe results
    logic             evalVec;   // a vector is applied this cycle
    logic             lastVec;   // it is the final vector of the set
    logic             setSel;    // 0 displacement set, 1 pin set
    logic [IDX_W-1:0] vecIdx;    // position inside the set
  } tstStrobes_t;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/nmaj_aoi_cell.sv
module nmaj_aoi_cell
  import nmaj_aoi_pkg::*;
(
  input  logic       a,
  input  logic       b,
  input  logic       c,
  input  logic       d,
  input  logic       e,
  input  logic [1:0] mode,
  output logic       f
);

  logic innerVote;
  logic goodOut;
  logic outCellOut;

  assign innerVote = maj3(~a, b, ~c);
  assign goodOut   = maj3(d, e, innerVote);

  // response of the cell when its output cell is displaced
  assign outCellOut = (~d & ~e)
                    | ((~d | ~e) & ((~a & b) | (b & ~c) | (~a & ~b & ~c)));

  always_comb begin
    unique case (defectMode_t'(mode))
      DM_NONE: f = goodOut;
      DM_BMOD: f = maj3(b, d, e);
      DM_BSEV: f = b;
      DM_OUTC: f = outCellOut;
      default: f = goodOut;
    endcase
  end

endmodule

// File: rtl/nmaj_aoi_adder.sv
module nmaj_aoi_adder
  import nmaj_aoi_pkg::*;
(
  input  logic x,
  input  logic y,
  input  logic cin,
  output logic sum,
  output logic carry
);

  logic midVote;

  // carry: inner voter forced to pass cin (A=0, C=1), outer votes x, y, cin
  nmaj_aoi_cell i_carryCell (
    .a(1'b0), .b(cin), .c(1'b1), .d(x), .e(y),
    .mode(DM_NONE), .f(carry)
  );

  // midVote = MAJ(x, y, !cin): inner voter yields !cin (A=cin, B=0, C=0)
  nmaj_aoi_cell i_midCell (
    .a(cin), .b(1'b0), .c(1'b0), .d(x), .e(y),
    .mode(DM_NONE), .f(midVote)
  );

  // sum = MAJ(cin, midVote, !carry)
  nmaj_aoi_cell i_sumCell (
    .a(carry), .b(1'b0), .c(1'b0), .d(cin), .e(midVote),
    .mode(DM_NONE), .f(sum)
  );

endmodule

// File: rtl/nmaj_aoi_tst_ctrl.sv
module nmaj_aoi_tst_ctrl
  import nmaj_aoi_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        setSel,
  output logic        busy,
  output tstStrobes_t stb
);

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} ctrlState_t;

  ctrlState_t       state;
  logic [IDX_W-1:0] idx;
  logic             setReg;
  logic [LEN_W-1:0] curLen;
  logic             atLast;
  logic             accept;

  assign curLen = setReg ? LEN_W'(PIN_LEN) : LEN_W'(DISP_LEN);
  assign atLast = ({1'b0, idx} == (curLen - LEN_W'(1)));
  assign accept = (state == ST_IDLE) && start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      idx    <= '0;
      setReg <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state  <= ST_RUN;
            idx    <= '0;
            setReg <= setSel;
          end
        end
        ST_RUN: begin
          if (atLast) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (state == ST_RUN);
  assign stb.clearRes = accept;
  assign stb.evalVec  = (state == ST_RUN);
  assign stb.lastVec  = (state == ST_RUN) && atLast;
  assign stb.setSel   = setReg;
  assign stb.vecIdx   = idx;

  // R7
  idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN) |-> ({1'b0, idx} < curLen));

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_RUN) && start && !atLast) |=> ((state == ST_RUN) && $stable(setReg)));

endmodule

// File: rtl/nmaj_aoi_tst_dp.sv
module nmaj_aoi_tst_dp
  import nmaj_aoi_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  tstStrobes_t      stb,
  input  logic [1:0]       dutMode,
  output logic             detect,
  output logic [VEC_W-1:0] failVec,
  output logic             done
);

  logic [VEC_W-1:0] curVec;
  logic             dutOut;
  logic             refOut;
  logic             mismatch;

  // vector bits {A,B,C,D,E}, A at the top
  always_comb begin
    if (!stb.setSel) begin
      curVec = (stb.vecIdx == IDX_W'(0)) ? 5'b00000 : 5'b00001;
    end else begin
      unique case (stb.vecIdx)
        IDX_W'(0): curVec = 5'b01110;
        IDX_W'(1): curVec = 5'b00101;
        IDX_W'(2): curVec = 5'b00000;
        default:   curVec = 5'b00001;
      endcase
    end
  end

  nmaj_aoi_cell i_dutCell (
    .a(curVec[4]), .b(curVec[3]), .c(curVec[2]), .d(curVec[1]), .e(curVec[0]),
    .mode(dutMode), .f(dutOut)
  );

  nmaj_aoi_cell i_refCell (
    .a(curVec[4]), .b(curVec[3]), .c(curVec[2]), .d(curVec[1]), .e(curVec[0]),
    .mode(DM_NONE), .f(refOut)
  );

  assign mismatch = stb.evalVec && (dutOut != refOut);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      detect  <= 1'b0;
      failVec <= '0;
      done    <= 1'b0;
    end else if (stb.clearRes) begin
      detect  <= 1'b0;
      failVec <= '0;
      done    <= 1'b0;
    end else begin
      if (mismatch && !detect) begin
        detect  <= 1'b1;
        failVec <= curVec;
      end
      if (stb.lastVec) begin
        done <= 1'b1;
      end
    end
  end

  // R8
  detect_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detect && !stb.clearRes) |=> detect);

  // R8
  failvec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (detect && !stb.clearRes) |=> $stable(failVec));

  // R9
  free_nodetect_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(detect) |-> ($past(dutMode) != 2'd0));

endmodule

// File: rtl/nmaj_aoi_top.sv
module nmaj_aoi_top
  import nmaj_aoi_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       gateA,
  input  logic       gateB,
  input  logic       gateC,
  input  logic       gateD,
  input  logic       gateE,
  input  logic [1:0] gateMode,
  output logic       gateOut,
  input  logic       addA,
  input  logic       addB,
  input  logic       addCin,
  output logic       addSum,
  output logic       addCarry,
  input  logic       tstStart,
  input  logic       tstSet,
  input  logic [1:0] tstMode,
  output logic       tstBusy,
  output logic       tstDone,
  output logic       tstDetect,
  output logic [4:0] tstFailVec
);

  tstStrobes_t stb;

  nmaj_aoi_cell i_gate (
    .a(gateA), .b(gateB), .c(gateC), .d(gateD), .e(gateE),
    .mode(gateMode), .f(gateOut)
  );

  nmaj_aoi_adder i_adder (
    .x(addA), .y(addB), .cin(addCin), .sum(addSum), .carry(addCarry)
  );

  nmaj_aoi_tst_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(tstStart), .setSel(tstSet),
    .busy(tstBusy), .stb(stb)
  );

  nmaj_aoi_tst_dp i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dutMode(tstMode),
    .detect(tstDetect), .failVec(tstFailVec), .done(tstDone)
  );

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(tstBusy && tstDone));

  // R7
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tstDone) |-> $past(tstBusy));

  // R12
  adder_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    addCarry == ((addA & addB) | (addA & addCin) | (addB & addCin)));

  // R12
  adder_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    addSum == (addA ^ addB ^ addCin));

endmodule

// File: tb/test_nmaj_aoi_top.sv
`timescale 1ns/1ps
module test_nmaj_aoi_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic gateA = 0, gateB = 0, gateC = 0, gateD = 0, gateE = 0;
  logic [1:0] gateMode = 2'd0;
  logic gateOut;
  logic addA = 0, addB = 0, addCin = 0;
  logic addSum, addCarry;
  logic tstStart = 0, tstSet = 0;
  logic [1:0] tstMode = 2'd0;
  logic tstBusy, tstDone, tstDetect;
  logic [4:0] tstFailVec;

  int nRun = 0;
  int nFail = 0;
  bit finished = 0;
  logic freeOut [32];

  always #2.5 clk = ~clk;

  nmaj_aoi_top i_nmaj_aoi_top (
    .clk(clk), .rstN(rstN),
    .gateA(gateA), .gateB(gateB), .gateC(gateC), .gateD(gateD), .gateE(gateE),
    .gateMode(gateMode), .gateOut(gateOut),
    .addA(addA), .addB(addB), .addCin(addCin), .addSum(addSum), .addCarry(addCarry),
    .tstStart(tstStart), .tstSet(tstSet), .tstMode(tstMode),
    .tstBusy(tstBusy), .tstDone(tstDone), .tstDetect(tstDetect), .tstFailVec(tstFailVec)
  );

  function automatic logic mj(input logic x, input logic y, input logic z);
    return (x + y + z) >= 2;
  endfunction

  function automatic logic model(input int mode, input logic [4:0] v);
    logic a, b, c, d, e;
    {a, b, c, d, e} = v;
    case (mode)
      0: return mj(d, e, mj(!a, b, !c));
      1: return mj(b, d, e);
      2: return b;
      default: return (!d && !e) || ((!d || !e) && ((!a && b) || (b && !c) || (!a && !b && !c)));
    endcase
  endfunction

  function automatic logic [4:0] setVec(input logic sel, input int i);
    logic [4:0] pinSet [4];
    pinSet = '{5'b01110, 5'b00101, 5'b00000, 5'b00001};
    if (!sel) return (i == 0) ? 5'b00000 : 5'b00001;
    return pinSet[i];
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveGate(input logic [4:0] v, input int mode);
    {gateA, gateB, gateC, gateD, gateE} = v;
    gateMode = 2'(mode);
    #1;
  endtask

  // one tester run; optional start poke while busy (R11)
  task automatic runTest(input logic sel, input int mode, input bit poke);
    int cyc;
    int len;
    logic expDet;
    logic [4:0] expVec;
    len = sel ? 4 : 2;
    expDet = 0;
    expVec = 0;
    for (int i = 0; i < len; i++) begin
      if (!expDet && (model(mode, setVec(sel, i)) != model(0, setVec(sel, i)))) begin
        expDet = 1;
        expVec = setVec(sel, i);
      end
    end
    @(negedge clk);
    tstMode = 2'(mode);
    tstSet = sel;
    tstStart = 1;
    @(posedge clk);
    @(negedge clk);
    tstStart = 0;
    check("R7 busy after start", tstBusy, 1);
    check("R7 done low while busy", tstDone, 0);
    cyc = 0;
    while (!tstDone && cyc < 20) begin
      @(posedge clk);
      @(negedge clk);
      cyc++;
      if (poke && cyc == 1) begin
        tstStart = 1;
        tstSet = ~sel;
      end else begin
        tstStart = 0;
        tstSet = sel;
      end
    end
    check(poke ? "R11 run length kept" : "R7 one vector per clock", cyc, len);
    check("R7 busy low at done", tstBusy, 0);
    check(sel ? "R10 detect pin set" : "R9 detect displacement set", tstDetect, expDet);
    check("R8 first failing vector", tstFailVec, expVec);
    if (!sel && mode != 0) check("R9 displacement set catches defect", tstDetect, 1);
    if (mode == 0) check("R9 fault-free never detects", tstDetect, 0);
    @(negedge clk);
    check("R7 done held", tstDone, 1);
    check("R8 detect held", tstDetect, expDet);
  endtask

  initial begin
    #500000;
    if (!finished) begin
      nFail++;
      nRun++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R13 reset state
    check("R13 busy", tstBusy, 0);
    check("R13 done", tstDone, 0);
    check("R13 detect", tstDetect, 0);
    check("R13 failVec", tstFailVec, 0);

    // R1, R3, R4, R5 exhaustive per defect select
    for (int m = 0; m < 4; m++) begin
      for (int v = 0; v < 32; v++) begin
        driveGate(5'(v), m);
        case (m)
          0: begin check("R1 fault-free", gateOut, model(0, 5'(v))); freeOut[v] = gateOut; end
          1: check("R3 B moderate", gateOut, model(1, 5'(v)));
          2: check("R4 B severe", gateOut, model(2, 5'(v)));
          default: check("R5 output cell", gateOut, model(3, 5'(v)));
        endcase
      end
    end

    // R6 self-duality over all 32 patterns
    for (int v = 0; v < 32; v++) check("R6 self-dual", freeOut[v], !freeOut[31 - v]);

    // R2 programmed gate forms
    for (int v = 0; v < 4; v++) begin
      logic a, c;
      {a, c} = 2'(v);
      driveGate({a, 1'b1, c, 1'b0, 1'b1}, 0);
      check("R2 NAND form", gateOut, !(a && c));
      driveGate({a, 1'b0, c, 1'b0, 1'b1}, 0);
      check("R2 NOR form", gateOut, !(a || c));
    end
    for (int v = 0; v < 8; v++) begin
      logic b, c, e;
      {b, c, e} = 3'(v);
      driveGate({1'b0, b, c, 1'b0, e}, 0);
      check("R2 two-level form", gateOut, e && (b || !c));
    end

    // R12 adder
    for (int v = 0; v < 8; v++) begin
      {addA, addB, addCin} = 3'(v);
      #1;
      check("R12 carry", addCarry, (addA + addB + addCin) >= 2);
      check("R12 sum", addSum, (addA + addB + addCin) % 2);
    end
    {addA, addB, addCin} = 3'b000;

    // R7..R10 tester runs for both sets and all modes
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 4; m++)
        runTest(1'(s), m, 0);

    // R11 start during a run is ignored
    runTest(1'b1, 3, 1);
    runTest(1'b0, 1, 1);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule